// File: doc/BRIEF.md
# Sigma-Delta Serial Input Sampler

This block sits between an external one-bit sigma-delta modulator and the downstream digital filter. It captures the modulator's serial bit stream in a plain clock-plus-data format and hands out one recovered bit per sampling event, together with a single-cycle strobe. All logic runs on one fast system clock. The serial data pin and the optional serial clock pin are brought into that domain through multi-flop synchronizers, and clock edges are found by comparing successive synchronized levels.

The block also produces a clock for the modulator: a square wave whose half period is a programmable number of system cycles. A two-bit source select decides which clock decides the sampling instants: the external clock pin, the generated clock itself, or one of two half-rate variants intended for modulators that divide their clock input by two before shifting data out. In the half-rate variants only every second qualifying edge of the generated clock produces a sample, and the alternation restarts each time the block is enabled.

Configuration (source, edge polarity, divider) is expected to be static while the block is enabled; the enable input gates sample production and restarts the half-rate alternation.

Top module: `sd_serial_sampler`

## Requirements
- R1: While rst_n is low, bit_valid, bit_out and mod_clk_out are all 0.
- R2: With div_val = N > 0, mod_clk_out is a square wave that holds each level for exactly N system cycles, starting low after reset; it runs regardless of enable.
- R3: With div_val = 0, mod_clk_out is driven low from the next system clock edge on and stays low.
- R4: With src_sel = 0, a sample is taken on each rising edge of ext_clk_in when edge_pol[0] = 0 and on each falling edge when edge_pol[0] = 1; edge_pol values 2 and 3 behave like 0 and 1.
- R5: With src_sel = 1, a sample is taken on each rising (edge_pol[0] = 0) or falling (edge_pol[0] = 1) edge of the generated clock mod_clk_out.
- R6: With src_sel = 2, a sample is taken on every second falling edge of mod_clk_out; edge_pol has no effect.
- R7: With src_sel = 3, a sample is taken on every second rising edge of mod_clk_out; edge_pol has no effect.
- R8: The half-rate alternation restarts while enable is low, so in modes 2 and 3 the first sample after enable rises is taken on the second qualifying edge.
- R9: bit_valid is high for exactly one system cycle per sample and never high in the cycle after a system edge at which enable was low.
- R10: Latency: when a new clock level (and the data pin value) is first captured at system clock edge k, bit_valid and bit_out show the result right after edge k+2; the internal clock follows the same delay so data stays aligned.
- R11: Sampled data always comes from ext_dat_in; in modes 1 to 3 activity on ext_clk_in has no effect on bit_out or bit_valid.
- R12: bit_out changes only together with a bit_valid pulse and otherwise holds the last sampled bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows sampling; low restarts half-rate alternation |
| src_sel | input | 2 | Sampling clock source: 0 pin, 1 generated clock, 2 half-rate on falling, 3 half-rate on rising |
| edge_pol | input | 2 | Bit 0 picks falling (1) or rising (0) edge in modes 0 and 1 |
| div_val | input | DIV_W | Half period of mod_clk_out in system cycles; 0 stops it |
| ext_clk_in | input | 1 | Serial clock from the modulator (asynchronous) |
| ext_dat_in | input | 1 | Serial data from the modulator (asynchronous) |
| mod_clk_out | output | 1 | Generated clock for the modulator |
| bit_out | output | 1 | Most recently sampled data bit |
| bit_valid | output | 1 | One-cycle strobe per sampled bit |

## Verification
The hardest situation to reach is the half-rate alternation phase just after enable: the first generated-clock edge after enable must be skipped and the second one sampled, and this depends on where the free-running divider happens to be when enable rises. The stimulus drops and raises enable several times at different divider phases in modes 2 and 3, and a cycle-exact reference model in the bench tracks the generated clock, the synchronizer delay and the alternation bit independently, so every skipped or taken edge is compared on every cycle. A directed single-edge sequence on the clock pin pins down the exact latency.

// File: rtl/sds_pkg.sv
package sds_pkg;

    // Sampling clock source selection
    typedef enum logic [1:0] {
        SRC_PIN    = 2'd0,  // external serial clock pin
        SRC_OCLK   = 2'd1,  // generated clock, both edges usable
        SRC_HALF_F = 2'd2,  // every second falling edge of generated clock
        SRC_HALF_R = 2'd3   // every second rising edge of generated clock
    } src_e;

    typedef struct packed {
        logic lvl;
    } edge_st_t;

    typedef struct packed {
        logic alt;
        logic bit_v;
        logic valid;
    } samp_st_t;

endpackage

// File: rtl/sds_sync.sv
module sds_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign d_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/sds_clkgen.sv
module sds_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             oclk
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (div_val == '0) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else if (st_q.cnt >= div_val - ONE) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oclk = st_q.lvl;

endmodule

// File: rtl/sds_edge_det.sv
module sds_edge_det
    import sds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic rise,
    output logic fall
);

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = lvl_in & ~st_q.lvl;
    assign fall = ~lvl_in & st_q.lvl;

endmodule

// File: rtl/sds_sampler.sv
module sds_sampler
    import sds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  src_e       src,
    input  logic [1:0] pol,
    input  logic       rise,
    input  logic       fall,
    input  logic       dat,
    output logic       bit_out,
    output logic       bit_valid
);

    samp_st_t st_d, st_q;
    logic     direct_hit;
    logic     qual;
    logic     hit;

    // modes 0 and 1: polarity decode, upper bit has no meaning
    always_comb begin
        unique case (pol)
            2'b00, 2'b10: direct_hit = rise;
            default:      direct_hit = fall;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        qual       = 1'b0;
        hit        = 1'b0;
        unique case (src)
            SRC_PIN, SRC_OCLK: begin
                hit      = direct_hit;
                st_d.alt = 1'b0;
            end
            SRC_HALF_F: begin
                qual = fall;
                hit  = fall & st_q.alt;
            end
            default: begin
                qual = rise;
                hit  = rise & st_q.alt;
            end
        endcase
        if (qual) begin
            st_d.alt = ~st_q.alt;
        end
        if (!enable) begin
            st_d.alt = 1'b0;
            hit      = 1'b0;
        end
        if (hit) begin
            st_d.valid = 1'b1;
            st_d.bit_v = dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out   = st_q.bit_v;
    assign bit_valid = st_q.valid;

endmodule

// File: rtl/sd_serial_sampler.sv
module sd_serial_sampler
    import sds_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       edge_pol,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ext_clk_in,
    input  logic             ext_dat_in,
    output logic             mod_clk_out,
    output logic             bit_out,
    output logic             bit_valid
);

    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pin_s;
    logic             oclk;
    logic             oclk_dly;
    logic             cur_lvl;
    logic             rise;
    logic             fall;
    src_e             src_m;

    assign src_m = src_e'(src_sel);

    // pin synchronizer: bit 1 serial clock, bit 0 serial data
    sds_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ext_clk_in, ext_dat_in}),
        .d_out (pin_s)
    );

    sds_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .oclk    (oclk)
    );

    // generated clock delayed by the same depth as the data path
    sds_sync #(.W(1), .STAGES(SYNC_STAGES)) u_oclk_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (oclk),
        .d_out (oclk_dly)
    );

    assign cur_lvl = (src_m == SRC_PIN) ? pin_s[1] : oclk_dly;

    sds_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (cur_lvl),
        .rise   (rise),
        .fall   (fall)
    );

    sds_sampler u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .src       (src_m),
        .pol       (edge_pol),
        .rise      (rise),
        .fall      (fall),
        .dat       (pin_s[0]),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    assign mod_clk_out = oclk;

endmodule

// File: rtl/sds_sampler_chk.sv
module sds_sampler_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       src_sel,
    input logic [DIV_W-1:0] div_val,
    input logic             mod_clk_out,
    input logic             bit_out,
    input logic             bit_valid
);

    // R9: strobe lasts one cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R9: no strobe after a disabled edge
    p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !bit_valid);

    // R3: zero divider forces the generated clock low
    p_divoff_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val == '0) |=> !mod_clk_out);

    // R12: data bit only moves with a strobe
    p_hold_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));

    // R8: half-rate modes never sample right after enable rises
    p_skip_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable) && src_sel[1]) |=> !bit_valid);

endmodule

bind sd_serial_sampler sds_sampler_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .src_sel     (src_sel),
    .div_val     (div_val),
    .mod_clk_out (mod_clk_out),
    .bit_out     (bit_out),
    .bit_valid   (bit_valid)
);

// File: tb/sd_serial_sampler_test.sv
module sd_serial_sampler_test;

    localparam int CLK_PER = 10;
    localparam int DW      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    src_sel = 2'd0;
    logic [1:0]    edge_pol = 2'd0;
    logic [DW-1:0] div_val = '0;
    logic          ext_clk_in = 1'b0;
    logic          ext_dat_in = 1'b0;
    logic          mod_clk_out;
    logic          bit_out;
    logic          bit_valid;

    always #(CLK_PER/2) clk = ~clk;

    sd_serial_sampler #(.DIV_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
        .edge_pol(edge_pol), .div_val(div_val), .ext_clk_in(ext_clk_in),
        .ext_dat_in(ext_dat_in), .mod_clk_out(mod_clk_out),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    string req = "R1";
    string clk_req = "R2";
    int    ext_half = 0;
    int    ext_cnt = 0;
    bit    rand_dat = 1;

    // reference model state
    bit ec[4];
    bit dt[4];
    bit ol[4];
    bit mock = 0;
    int mcnt = 0;
    int psrc = 0;
    bit malt = 0;
    bit mbit = 0;
    bit mval = 0;

    task automatic chk(string r, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    // behaviour at the coming rising edge, from the inputs it will capture
    task automatic model_edge();
        bit cur, prv, rs, fl, fire;
        for (int i = 3; i > 0; i--) begin
            ec[i] = ec[i-1];
            dt[i] = dt[i-1];
            ol[i] = ol[i-1];
        end
        ec[0] = ext_clk_in;
        dt[0] = ext_dat_in;
        ol[0] = mock;
        if (div_val == 0) begin
            mcnt = 0;
            mock = 0;
        end else if (mcnt + 1 >= int'(div_val)) begin
            mcnt = 0;
            mock = !mock;
        end else begin
            mcnt++;
        end
        cur  = (src_sel == 0) ? ec[2] : ol[2];
        prv  = (psrc == 0) ? ec[3] : ol[3];
        psrc = int'(src_sel);
        rs   = cur && !prv;
        fl   = !cur && prv;
        fire = 0;
        case (src_sel)
            2'd0, 2'd1: begin
                fire = edge_pol[0] ? fl : rs;
                malt = 0;
            end
            2'd2: if (fl) begin fire = malt; malt = !malt; end
            default: if (rs) begin fire = malt; malt = !malt; end
        endcase
        if (!enable) begin
            fire = 0;
            malt = 0;
        end
        mval = fire;
        if (fire) mbit = dt[2];
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(req, "bit_valid", int'(bit_valid), int'(mval));
        chk(req, "bit_out(R12)", int'(bit_out), int'(mbit));
        chk(clk_req, "mod_clk_out", int'(mod_clk_out), int'(mock));
        if (ext_half > 0) begin
            ext_cnt++;
            if (ext_cnt >= ext_half) begin
                ext_cnt = 0;
                ext_clk_in = ~ext_clk_in;
            end
        end
        if (rand_dat) ext_dat_in = 1'($urandom_range(0, 1));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ol[i] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "bit_valid", int'(bit_valid), 0);
        chk("R1", "bit_out", int'(bit_out), 0);
        chk("R1", "mod_clk_out", int'(mod_clk_out), 0);
        rst_n = 1'b1;

        // R2 / R9: divider running, sampling disabled
        div_val = 8'd3; ext_half = 4; req = "R9";
        run(30);

        // R4: pin clock, all polarity codes
        req = "R4"; edge_pol = 2'd0; enable = 1; run(200);
        enable = 0; run(5);
        edge_pol = 2'd1; enable = 1; run(200);
        edge_pol = 2'd2; run(100);
        edge_pol = 2'd3; run(100);
        enable = 0; run(5);

        // R5 / R11: generated clock, pin clock toggling fast
        src_sel = 2'd1; edge_pol = 2'd0; ext_half = 1; req = "R5";
        run(4); enable = 1; run(200);
        edge_pol = 2'd1; run(200);
        req = "R11"; div_val = 8'd2; run(200);

        // R6 / R8: half-rate on falling edges
        enable = 0; div_val = 8'd3; src_sel = 2'd2; req = "R6"; run(4);
        enable = 1; run(100);
        edge_pol = 2'd0; run(100);
        req = "R8";
        for (int k = 0; k < 6; k++) begin
            enable = 0; run(2 + k);
            enable = 1; run(15 + k);
        end

        // R7 / R8: half-rate on rising edges
        enable = 0; src_sel = 2'd3; div_val = 8'd4; req = "R7"; run(4);
        enable = 1; edge_pol = 2'd1; run(150);
        req = "R8";
        for (int k = 0; k < 6; k++) begin
            enable = 0; run(3 + k);
            enable = 1; run(20 + k);
        end

        // R10: single directed edge on the pin clock
        enable = 0; src_sel = 2'd0; edge_pol = 2'd0; ext_half = 0; rand_dat = 0;
        ext_clk_in = 0; ext_dat_in = 0; req = "R10"; run(6);
        enable = 1; run(4);
        ext_clk_in = 1; ext_dat_in = 1;
        run(2);
        chk("R10", "no strobe before edge k+2", int'(bit_valid), 0);
        run(1);
        chk("R10", "strobe after edge k+2", int'(bit_valid), 1);
        chk("R10", "bit after edge k+2", int'(bit_out), 1);
        ext_clk_in = 0; ext_dat_in = 0; run(6);

        // R3: divider stopped
        rand_dat = 1; src_sel = 2'd1; edge_pol = 2'd1; clk_req = "R3"; req = "R3";
        div_val = 8'd0; run(40);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule